// File: doc/BRIEF.md
# Dual-Rail Jitter-Smoothing Elastic Store

This block sits behind a clock-and-data recovery stage on a line receiver. Recovered bits arrive on two rails, one carrying positive pulses and one carrying negative pulses. Each bit comes with a write enable that is already synchronous to one fast reference clock. That clock runs at eight times the nominal bit rate. The block stores the bit pairs in a small circular buffer and reads them back out at a steady rate. Because the reads follow a local divider and not the irregular write timing, the read stream is free of the write-side jitter.

A nominal read period is eight reference ticks. The buffer length is sampled at the end of every read period, and that sample sets the length of the period that follows. A buffer close to full gives a period one tick shorter, so reads drain it faster. A buffer close to empty gives a period one tick longer. A buffer anywhere between gives the nominal length. Each adjustment is one eighth of a bit.

At reset the write position starts half a buffer ahead of the read position. This gives an average latency of half the depth. No overflow or underflow flags exist. Extreme cases are handled quietly: a write into a full buffer is dropped, and a read from an empty buffer yields zeros.

Top module: `rail_elastic_store`

## Requirements
- R1: While reset is asserted, the outputs are rd_stb=0, rd_pos=0, rd_neg=0 and fill=16, which is half of the 32-entry depth.
- R2: rd_stb is a one-cycle pulse. After reset is released, the first pulse appears after the 8th rising clock edge, and none appears after edges 1 to 7.
- R3: If fill is 30 or more at the end of a read period, the next period lasts 7 ticks.
- R4: If fill is 2 or less at the end of a read period, the next period lasts 9 ticks.
- R5: Otherwise the next period lasts 8 ticks. Every period between two strobes is therefore 7, 8 or 9 ticks.
- R6: The bit pairs leave in the order they were written. rd_pos and rd_neg change only together with rd_stb, and they hold their value between strobes.
- R7: A write and a read on the same reference tick leave fill unchanged.
- R8: A write while fill is 32 and no read occurs on that tick is dropped, so fill never exceeds 32.
- R9: A read while fill is 0 gives rd_pos=0 and rd_neg=0, and fill stays 0 unless a write lands on that tick.
- R10: After reset, the first bit pair written comes out at the 17th read strobe. The 16 strobes before it return zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at 8x bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-tick write enable from the recovery stage |
| wr_pos | input | 1 | Positive-rail bit to store |
| wr_neg | input | 1 | Negative-rail bit to store |
| rd_stb | output | 1 | One-tick strobe that marks a new output bit |
| rd_pos | output | 1 | Smoothed positive-rail bit |
| rd_neg | output | 1 | Smoothed negative-rail bit |
| fill | output | 6 | Number of stored entries, 0 to 32 |

## Verification
A write raises fill one edge later. A read decided on edge N makes rd_stb, rd_pos, rd_neg and the reduced fill visible after that same edge N, all together. The bench drives its inputs and samples the outputs on falling edges, half a period clear of the edge that commits them. A reference model steps on the same rising edges, so every comparison sees values that were settled by exactly one edge. Directed cases count edges from reset release to the 8th edge for the first strobe and the simultaneous write. They count strobes to the 17th for the first stored pair.

// File: rtl/res_pkg.sv
package res_pkg;

    // Length class of the read period that is currently running
    typedef enum logic [1:0] {
        PER_NOM   = 2'd0,
        PER_SHORT = 2'd1,
        PER_LONG  = 2'd2
    } per_mode_e;

    // One stored line bit: positive and negative rail
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

endpackage

// File: rtl/res_strobe_gen.sv
module res_strobe_gen
    import res_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int GUARD     = 2,
    parameter int NOM_TICKS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                       fire
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int CNT_W  = $clog2(NOM_TICKS + 2);
    localparam int GW     = CNT_W + 1;

    localparam logic [FILL_W-1:0] HI_L       = FILL_W'(DEPTH - GUARD);
    localparam logic [FILL_W-1:0] LO_L       = FILL_W'(GUARD);
    localparam logic [CNT_W-1:0]  LAST_NOM   = CNT_W'(NOM_TICKS - 1);
    localparam logic [CNT_W-1:0]  LAST_SHORT = CNT_W'(NOM_TICKS - 2);
    localparam logic [CNT_W-1:0]  LAST_LONG  = CNT_W'(NOM_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        per_mode_e        mode;
    } sg_state_t;

    sg_state_t        st_q, st_d;
    logic [CNT_W-1:0] last_tick;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            PER_SHORT: last_tick = LAST_SHORT;
            PER_LONG:  last_tick = LAST_LONG;
            default:   last_tick = LAST_NOM;
        endcase
        fire = (st_q.cnt == last_tick);
        if (fire) begin
            st_d.cnt = '0;
            if (fill >= HI_L) begin
                st_d.mode = PER_SHORT;
            end else if (fill <= LO_L) begin
                st_d.mode = PER_LONG;
            end else begin
                st_d.mode = PER_NOM;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.mode <= PER_NOM;
        end else begin
            st_q <= st_d;
        end
    end

    // Independent period meter: ticks since the last strobe and the length owed
    localparam logic [GW-1:0] W_NOM   = GW'(NOM_TICKS);
    localparam logic [GW-1:0] W_SHORT = GW'(NOM_TICKS - 1);
    localparam logic [GW-1:0] W_LONG  = GW'(NOM_TICKS + 1);

    logic [GW-1:0] gap_q, want_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= GW'(1);
            want_q <= W_NOM;
        end else if (fire) begin
            gap_q  <= GW'(1);
            if (fill >= HI_L) begin
                want_q <= W_SHORT;
            end else if (fill <= LO_L) begin
                want_q <= W_LONG;
            end else begin
                want_q <= W_NOM;
            end
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_short_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && want_q == W_SHORT) |-> gap_q == W_SHORT);
    assert_long_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && want_q == W_LONG) |-> gap_q == W_LONG);
    assert_nominal_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && want_q == W_NOM) |-> gap_q == W_NOM);
    assert_period_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= W_LONG);

endmodule

// File: rtl/res_fill_ctrl.sv
module res_fill_ctrl #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       fire,
    output logic                       wr_ok,
    output logic                       rd_ok,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0]  PTR_HALF = PTR_W'(DEPTH / 2);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);
    localparam logic [FILL_W-1:0] FILL_HALF = FILL_W'(DEPTH / 2);

    typedef struct packed {
        logic [PTR_W-1:0]  wp;
        logic [PTR_W-1:0]  rp;
        logic [FILL_W-1:0] lvl;
    } fc_state_t;

    fc_state_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        rd_ok = fire && (st_q.lvl != '0);
        wr_ok = wr_en && ((st_q.lvl != FILL_MAX) || rd_ok);
        if (wr_ok) begin
            st_d.wp = ptr_step(st_q.wp);
        end
        if (rd_ok) begin
            st_d.rp = ptr_step(st_q.rp);
        end
        st_d.lvl = st_q.lvl + FILL_W'(wr_ok) - FILL_W'(rd_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wp  <= PTR_HALF;
            st_q.rp  <= '0;
            st_q.lvl <= FILL_HALF;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wp;
    assign rd_ptr = st_q.rp;
    assign fill   = st_q.lvl;

    assert_same_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fire && fill != '0) |=> $stable(fill));
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_MAX && !fire) |=> fill == FILL_MAX);
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_MAX);
    assert_empty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && fill == '0 && !wr_en) |=> fill == '0);

endmodule

// File: rtl/res_rail_store.sv
module res_rail_store
    import res_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_ok,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr,
    input  rail_t                    wr_data,
    input  logic                     fire,
    input  logic                     rd_ok,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr,
    output logic                     rd_stb,
    output rail_t                    rd_data
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic  stb;
        rail_t data;
    } out_state_t;

    rail_t      mem_q [DEPTH];
    rail_t      mem_d [DEPTH];
    logic [DEPTH-1:0] ent_we;
    out_state_t out_q, out_d;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry_we
        assign ent_we[gi] = wr_ok && (wr_ptr == PTR_W'(gi));
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = ent_we[i] ? wr_data : mem_q[i];
        end
        out_d     = out_q;
        out_d.stb = fire;
        if (fire) begin
            out_d.data = rd_ok ? mem_q[rd_ptr] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            out_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
            out_q <= out_d;
        end
    end

    assign rd_stb  = out_q.stb;
    assign rd_data = out_q.data;

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);
    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> $stable(rd_data));
    assert_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !rd_ok) |=> (rd_stb && rd_data == '0));

endmodule

// File: rtl/rail_elastic_store.sv
module rail_elastic_store
    import res_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int GUARD     = 2,
    parameter int NOM_TICKS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_pos,
    input  logic                       wr_neg,
    output logic                       rd_stb,
    output logic                       rd_pos,
    output logic                       rd_neg,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic              fire, wr_ok, rd_ok;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [FILL_W-1:0] fill_lvl;
    rail_t             wr_data, rd_data;

    assign wr_data.pos = wr_pos;
    assign wr_data.neg = wr_neg;

    res_strobe_gen #(
        .DEPTH     (DEPTH),
        .GUARD     (GUARD),
        .NOM_TICKS (NOM_TICKS)
    ) strobe_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fill  (fill_lvl),
        .fire  (fire)
    );

    res_fill_ctrl #(
        .DEPTH (DEPTH)
    ) fill_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .fire   (fire),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .fill   (fill_lvl)
    );

    res_rail_store #(
        .DEPTH (DEPTH)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .fire    (fire),
        .rd_ok   (rd_ok),
        .rd_ptr  (rd_ptr),
        .rd_stb  (rd_stb),
        .rd_data (rd_data)
    );

    assign rd_pos = rd_data.pos;
    assign rd_neg = rd_data.neg;
    assign fill   = fill_lvl;

endmodule

// File: tb/rail_elastic_store_tb.sv
module rail_elastic_store_tb_top;
    localparam int DEPTH = 32;
    localparam int GUARD = 2;
    localparam int NOM   = 8;
    localparam int PH_N  = 6;
    // stimulus vectors: write interval (0 = no writes) and phase length in cycles
    localparam int PH_GAP [PH_N] = '{8, 4, 16, 0, 1, 8};
    localparam int PH_LEN [PH_N] = '{400, 500, 1500, 150, 80, 400};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_pos = 1'b0;
    logic       wr_neg = 1'b0;
    logic       rd_stb, rd_pos, rd_neg;
    logic [5:0] fill;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rail_elastic_store dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_pos (wr_pos),
        .wr_neg (wr_neg),
        .rd_stb (rd_stb),
        .rd_pos (rd_pos),
        .rd_neg (rd_neg),
        .fill   (fill)
    );

    // Reference model built from the requirements
    int       m_cnt, m_len, m_wr, m_rd, m_fill, m_f0;
    bit       m_stb, m_pos, m_neg, m_fire, m_rdok, m_wrok;
    bit [1:0] m_mem [DEPTH];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_len = NOM; m_wr = DEPTH / 2; m_rd = 0;
            m_fill = DEPTH / 2; m_stb = 0; m_pos = 0; m_neg = 0;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 2'b00;
        end else begin
            m_f0   = m_fill;
            m_fire = (m_cnt == m_len - 1);
            m_rdok = m_fire && (m_f0 > 0);
            m_wrok = wr_en && ((m_f0 < DEPTH) || m_rdok);
            m_stb  = m_fire;
            if (m_fire) {m_pos, m_neg} = m_rdok ? m_mem[m_rd] : 2'b00;
            if (m_rdok) m_rd = (m_rd + 1) % DEPTH;
            if (m_wrok) begin
                m_mem[m_wr] = {wr_pos, wr_neg};
                m_wr = (m_wr + 1) % DEPTH;
            end
            m_fill = m_f0 + int'(m_wrok) - int'(m_rdok);
            if (m_fire) begin
                m_cnt = 0;
                m_len = (m_f0 >= DEPTH - GUARD) ? NOM - 1 :
                        (m_f0 <= GUARD) ? NOM + 1 : NOM;
            end else begin
                m_cnt++;
            end
        end
    end

    // Observed strobe spacing at the ports
    bit track = 1'b0;
    bit have_prev = 1'b0;
    int gap = 0, gap_min = 1000, gap_max = 0, seen7 = 0, seen9 = 0;

    always @(negedge clk) begin
        if (track) begin
            gap++;
            if (rd_stb) begin
                if (have_prev) begin
                    if (gap < gap_min) gap_min = gap;
                    if (gap > gap_max) gap_max = gap;
                    if (gap == NOM - 1) seen7++;
                    if (gap == NOM + 1) seen9++;
                end
                gap = 0;
                have_prev = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int k = 0;
        int first_at;
        int nstb;

        // R1: reset values
        repeat (2) @(negedge clk);
        chk(rd_stb == 1'b0 && rd_pos == 1'b0 && rd_neg == 1'b0, "R1 outputs", {rd_stb, rd_pos, rd_neg}, 0);
        chk(fill == 6'd16, "R1 fill", fill, 16);

        // Vector table walk against the reference model
        rst_n = 1'b1;
        track = 1'b1;
        for (int p = 0; p < PH_N; p++) begin
            for (int c = 0; c < PH_LEN[p]; c++) begin
                @(negedge clk);
                if (rd_stb !== m_stb) begin
                    chk(1'b0, "R2 strobe", rd_stb, m_stb);
                end else if (rd_pos !== m_pos || rd_neg !== m_neg) begin
                    chk(1'b0, "R6 data", {rd_pos, rd_neg}, {m_pos, m_neg});
                end else if (int'(fill) != m_fill) begin
                    chk(1'b0, "R7 fill", fill, m_fill);
                end else begin
                    chk(1'b1, "vector", 0, 0);
                end
                k++;
                wr_en  = (PH_GAP[p] != 0) && (c % ((PH_GAP[p] == 0) ? 1 : PH_GAP[p]) == 0);
                wr_pos = k[0];
                wr_neg = k[1] ^ k[2];
            end
            if (p == 3) begin
                chk(fill == 6'd0, "R9 fill empty", fill, 0);
                chk(rd_pos == 1'b0 && rd_neg == 1'b0, "R9 zero data", {rd_pos, rd_neg}, 0);
            end
            if (p == 4) begin
                chk(fill == 6'd32, "R8 full holds", fill, 32);
            end
        end
        track = 1'b0;
        chk(seen7 > 0, "R3 short period seen", seen7, 1);
        chk(seen9 > 0, "R4 long period seen", seen9, 1);
        chk(gap_min >= NOM - 1 && gap_max <= NOM + 1, "R5 period range", gap_max, NOM + 1);

        // R2 and R7: first strobe on edge 8, with a write on the same tick
        do_reset();
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            chk(rd_stb == 1'b0, "R2 no early strobe", rd_stb, 0);
        end
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_stb == 1'b1, "R2 strobe at edge 8", rd_stb, 1);
        chk(fill == 6'd16, "R7 simultaneous", fill, 16);

        // R10: first written pair emerges at the 17th strobe
        do_reset();
        wr_en = 1'b1; wr_pos = 1'b1; wr_neg = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_pos = 1'b0; wr_neg = 1'b0;
        first_at = 0;
        nstb = 0;
        for (int i = 0; i < 300; i++) begin
            if (rd_stb) begin
                nstb++;
                if (first_at == 0 && rd_pos && rd_neg) first_at = nstb;
            end
            @(negedge clk);
        end
        chk(first_at == 17, "R10 latency", first_at, 17);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule